// File: doc/BRIEF.md
# Three-Wire Display Register Write Master

This block drives a write-only serial link to a display driver chip. The link has three lines: an active-low chip select, a serial clock and a data-out line. A client hands the block one request through a valid/ready port. A register write carries an 8-bit register number and a 16-bit value. The block turns it into two separate chip-select frames. The first carries the register number and the second carries the value.

A second request kind sends only the register-number frame. Firmware uses it to leave the panel pointed at its display-memory data register, so that later pixel traffic lands in display memory. That pixel traffic goes through another path, not this block.

All bit timing is counted in time units. One unit is a programmable number of system clocks, taken from an input when the request is accepted. Each frame is 24 bits long: a start byte that marks the frame kind, then a 16-bit payload. Fixed guard times surround the chip-select edges. A busy flag and a one-clock completion pulse let the client sequence its requests.

Top module: `rw3_reg_writer`

## Requirements
- R1: While no transfer is running, and in the cycle after reset, `lcd_cs_n`, `lcd_sclk` and `lcd_sdo` are all high.
- R2: A frame carries 24 bits, most significant bit first: the start byte in bits 23..16, the payload high byte in bits 15..8 and the payload low byte in bits 7..0.
- R3: Each bit takes 5 units. For 1 unit `lcd_sclk` is low and `lcd_sdo` holds the bit. For the next unit `lcd_sclk` is high and `lcd_sdo` still holds the bit. For the last 3 units both lines are high.
- R4: Each frame opens with 1 unit of chip select high, followed by 10 units of chip select low before the first falling clock edge. Chip select goes high once the last bit's 3-unit gap ends, and stays high for 1 more unit before the frame counts as finished. A frame therefore lasts 132 units.
- R5: A register write (`req_index_only`=0) sends an index frame with start byte 0x70 and payload {0x00, `req_reg`}. After exactly one idle clock it sends a data frame with start byte 0x72 and payload `req_data`.
- R6: An index-only request (`req_index_only`=1) sends just the 0x70 frame with payload {0x00, `req_reg`}.
- R7: One unit lasts `unit_div`+1 clocks. The value is captured in the acceptance cycle, so later changes to `unit_div` do not affect that transfer.
- R8: `req_ready` is the inverse of `busy`. A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. Requests presented while busy are ignored and do not change the transfer in progress.
- R9: `busy` rises in the cycle after acceptance. It falls in the cycle where `done` is high for a single clock, which is the clock after the last frame's trailing unit ends.
- R10: A synchronous, active-high `rst` abandons any transfer. From the next cycle the lines are idle, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_div | input | DIV_W | Unit length minus one, in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_index_only | input | 1 | 1: send only the index frame |
| req_reg | input | 8 | Register number |
| req_data | input | 16 | Register value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse when the request finishes |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_sclk | output | 1 | Serial clock, idles high |
| lcd_sdo | output | 1 | Serial data out, idles high |

## Verification
The bench predicts the level of all three lines, and of busy, done and ready, in every clock of each transfer. Both request kinds are run at unit lengths of 1, 2 and 3 clocks. Payloads of all zeros, all ones and alternating bits separate a swapped byte order or a reversed bit order from a correct one. A changing `unit_div` and conflicting requests are applied in mid-transfer to show that the transfer ignores them. A reset in the middle of a frame shows that the transfer is dropped, and a clean transfer afterwards shows that nothing is left over.

// File: rtl/rw3_pkg.sv
package rw3_pkg;

    localparam logic [7:0] START_INDEX = 8'h70;
    localparam logic [7:0] START_DATA  = 8'h72;
    localparam int         FRAME_BITS  = 24;
    localparam int         BIT_IDX_W   = $clog2(FRAME_BITS);

    // Phase lengths in units
    localparam int UNITS_PRE   = 1;
    localparam int UNITS_SETUP = 10;
    localparam int UNITS_LOW   = 1;
    localparam int UNITS_HIGH  = 1;
    localparam int UNITS_GAP   = 3;
    localparam int UNITS_POST  = 1;
    localparam int UCNT_W      = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_GAP,
        PH_POST
    } phase_e;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_INDEX,
        TS_DATA
    } top_st_e;

endpackage

// File: rtl/rw3_unit_timer.sv
module rw3_unit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        tick_o = 1'b0;
        if (!run_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == div_i) begin
            tmr_d.cnt = '0;
            tick_o    = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    // R7: the count never passes the programmed unit length
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        tmr_q.cnt <= div_i);

endmodule

// File: rtl/rw3_frame_engine.sv
module rw3_frame_engine
    import rw3_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [7:0]  start_byte_i,
    input  logic [15:0] payload_i,
    input  logic        tick_i,
    output logic        active_o,
    output logic        frame_done_o,
    output logic        cs_n_o,
    output logic        sclk_o,
    output logic        sdo_o
);

    typedef struct packed {
        phase_e                  phase;
        logic [UCNT_W-1:0]       ucnt;
        logic [BIT_IDX_W-1:0]    bidx;
        logic [FRAME_BITS-1:0]   shreg;
        logic                    done;
    } eng_s;

    eng_s eng_d, eng_q;

    function automatic logic [UCNT_W-1:0] last_unit(phase_e ph);
        case (ph)
            PH_PRE:   return UCNT_W'(UNITS_PRE - 1);
            PH_SETUP: return UCNT_W'(UNITS_SETUP - 1);
            PH_LOW:   return UCNT_W'(UNITS_LOW - 1);
            PH_HIGH:  return UCNT_W'(UNITS_HIGH - 1);
            PH_GAP:   return UCNT_W'(UNITS_GAP - 1);
            PH_POST:  return UCNT_W'(UNITS_POST - 1);
            default:  return '0;
        endcase
    endfunction

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (eng_q.phase == PH_IDLE) begin
            if (start_i) begin
                eng_d.phase = PH_PRE;
                eng_d.ucnt  = '0;
                eng_d.bidx  = '0;
                eng_d.shreg = {start_byte_i, payload_i};
            end
        end else if (tick_i) begin
            if (eng_q.ucnt != last_unit(eng_q.phase)) begin
                eng_d.ucnt = eng_q.ucnt + 1'b1;
            end else begin
                eng_d.ucnt = '0;
                case (eng_q.phase)
                    PH_PRE:   eng_d.phase = PH_SETUP;
                    PH_SETUP: eng_d.phase = PH_LOW;
                    PH_LOW:   eng_d.phase = PH_HIGH;
                    PH_HIGH:  eng_d.phase = PH_GAP;
                    PH_GAP: begin
                        if (eng_q.bidx == BIT_IDX_W'(FRAME_BITS - 1)) begin
                            eng_d.phase = PH_POST;
                        end else begin
                            eng_d.phase = PH_LOW;
                            eng_d.bidx  = eng_q.bidx + 1'b1;
                            eng_d.shreg = {eng_q.shreg[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                    PH_POST: begin
                        eng_d.phase = PH_IDLE;
                        eng_d.done  = 1'b1;
                    end
                    default: eng_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q       <= '0;
            eng_q.phase <= PH_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign active_o     = (eng_q.phase != PH_IDLE);
    assign frame_done_o = eng_q.done;
    assign cs_n_o       = (eng_q.phase == PH_IDLE) || (eng_q.phase == PH_PRE) ||
                          (eng_q.phase == PH_POST);
    assign sclk_o       = (eng_q.phase != PH_LOW);
    assign sdo_o        = ((eng_q.phase == PH_LOW) || (eng_q.phase == PH_HIGH)) ?
                          eng_q.shreg[FRAME_BITS-1] : 1'b1;

    // R3: data does not change across the rising clock edge
    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> (sdo_o == $past(sdo_o)));

    // R4: falling clock edges only inside an already-selected frame
    p_fall_in_cs_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> (!cs_n_o && $past(!cs_n_o)));

    // R1: a finished frame leaves the lines idle
    p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> (cs_n_o && sclk_o && sdo_o && $past(cs_n_o)));

endmodule

// File: rtl/rw3_reg_writer.sv
module rw3_reg_writer
    import rw3_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] unit_div,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_index_only,
    input  logic [7:0]       req_reg,
    input  logic [15:0]      req_data,
    output logic             busy,
    output logic             done,
    output logic             lcd_cs_n,
    output logic             lcd_sclk,
    output logic             lcd_sdo
);

    typedef struct packed {
        top_st_e          st;
        logic             idx_only;
        logic [15:0]      data;
        logic [DIV_W-1:0] div;
        logic             done;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic        eng_start;
    logic [7:0]  eng_byte;
    logic [15:0] eng_payload;
    logic        eng_active;
    logic        eng_frame_done;
    logic        unit_tick;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        eng_start   = 1'b0;
        eng_byte    = START_INDEX;
        eng_payload = {8'h00, req_reg};
        case (ctl_q.st)
            TS_IDLE: begin
                if (req_valid) begin
                    eng_start      = 1'b1;
                    ctl_d.st       = TS_INDEX;
                    ctl_d.idx_only = req_index_only;
                    ctl_d.data     = req_data;
                    ctl_d.div      = unit_div;
                end
            end
            TS_INDEX: begin
                if (eng_frame_done) begin
                    if (ctl_q.idx_only) begin
                        ctl_d.st   = TS_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        eng_start   = 1'b1;
                        eng_byte    = START_DATA;
                        eng_payload = ctl_q.data;
                        ctl_d.st    = TS_DATA;
                    end
                end
            end
            TS_DATA: begin
                if (eng_frame_done) begin
                    ctl_d.st   = TS_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            ctl_q.st <= TS_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st != TS_IDLE);
    assign req_ready = !busy;
    assign done      = ctl_q.done;

    rw3_unit_timer #(
        .DIV_W (DIV_W)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (eng_active),
        .div_i  (ctl_q.div),
        .tick_o (unit_tick)
    );

    rw3_frame_engine i_engine (
        .clk          (clk),
        .rst          (rst),
        .start_i      (eng_start),
        .start_byte_i (eng_byte),
        .payload_i    (eng_payload),
        .tick_i       (unit_tick),
        .active_o     (eng_active),
        .frame_done_o (eng_frame_done),
        .cs_n_o       (lcd_cs_n),
        .sclk_o       (lcd_sclk),
        .sdo_o        (lcd_sdo)
    );

    // R8: an offered request while idle makes the block busy
    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    // R8: requests during a transfer leave the held value alone
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(ctl_q.data));

    // R9: completion lasts a single clock
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: completion marks the end of busy
    p_done_end_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R5: a new frame is launched only into an idle engine
    p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !eng_active);

endmodule

// File: tb/test_rw3_reg_writer.sv
module test_rw3_reg_writer;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int FRAME_U    = 132;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] unit_div = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_index_only = 1'b0;
    logic [7:0]       req_reg = '0;
    logic [15:0]      req_data = '0;
    logic             busy, done, lcd_cs_n, lcd_sclk, lcd_sdo;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rw3_reg_writer #(.DIV_W(DIV_W)) i_rw3_reg_writer (
        .clk            (clk),
        .rst            (rst),
        .unit_div       (unit_div),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_index_only (req_index_only),
        .req_reg        (req_reg),
        .req_data       (req_data),
        .busy           (busy),
        .done           (done),
        .lcd_cs_n       (lcd_cs_n),
        .lcd_sclk       (lcd_sclk),
        .lcd_sdo        (lcd_sdo)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at t=%0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Expected {cs_n, sclk, sdo} at clock m of a frame (R2, R3, R4)
    function automatic logic [2:0] frame_lines(int m, int u_len, logic [23:0] w);
        int u = m / u_len;
        if (u < 1)   return 3'b111;
        if (u < 11)  return 3'b011;
        if (u < 131) begin
            int b  = (u - 11) / 5;
            int ph = (u - 11) % 5;
            if (ph == 0) return {2'b00, w[23-b]};
            if (ph == 1) return {2'b01, w[23-b]};
            return 3'b011;
        end
        return 3'b111;
    endfunction

    function automatic string line_tag(int m, int u_len);
        int u = m / u_len;
        if (u < 11 || u >= 131) return "R4 guard";
        return "R2 R3 bit";
    endfunction

    // One request, checked in every cycle until completion.
    // disturb: present a conflicting request and a new unit_div mid-transfer (R7, R8)
    task automatic run_req(input logic idx_only, input logic [7:0] rg,
                           input logic [15:0] dat, input int div, input bit disturb,
                           input string name);
        int u_len = div + 1;
        int f     = FRAME_U * u_len;
        int s2    = f + 1;
        int fin   = idx_only ? f + 1 : s2 + f + 1;
        logic [23:0] w1 = {8'h70, 8'h00, rg};
        logic [23:0] w2 = {8'h72, dat};
        @(negedge clk);
        check({name, " R8 ready before accept"}, {7'd0, req_ready}, 8'd1);
        req_valid      = 1'b1;
        req_index_only = idx_only;
        req_reg        = rg;
        req_data       = dat;
        unit_div       = DIV_W'(div);
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n <= fin; n++) begin
            logic [2:0] exp;
            string      tg;
            if (n < f) begin
                exp = frame_lines(n, u_len, w1);
                tg  = line_tag(n, u_len);
            end else if (!idx_only && n >= s2 && n < s2 + f) begin
                exp = frame_lines(n - s2, u_len, w2);
                tg  = {"R5 data frame ", line_tag(n - s2, u_len)};
            end else begin
                exp = 3'b111;
                tg  = idx_only ? "R6 R1 idle" : "R5 R1 idle";
            end
            check({name, " ", tg}, {5'd0, lcd_cs_n, lcd_sclk, lcd_sdo}, {5'd0, exp});
            check({name, " R9 busy/done"}, {5'd0, busy, done, req_ready},
                  {5'd0, (n < fin), (n == fin), !(n < fin)});
            if (disturb && n == 7) begin
                req_valid      = 1'b1;
                req_index_only = ~idx_only;
                req_reg        = ~rg;
                req_data       = ~dat;
                unit_div       = DIV_W'(div + 3);
            end
            if (n == fin - 1) begin
                req_valid = 1'b0;
                unit_div  = DIV_W'(div);
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 R10: idle after reset
        check("R1 R10 reset lines", {5'd0, lcd_cs_n, lcd_sclk, lcd_sdo}, 8'h07);
        check("R10 reset busy/done", {6'd0, busy, done}, 8'h00);

        for (int d = 0; d < 3; d++) begin
            run_req(1'b1, 8'h22, 16'h0000, d, 1'b0, "R6 index-only 0x22");
            run_req(1'b0, 8'h5A, 16'hA5C3, d, 1'b0, "R5 write alt");
        end
        run_req(1'b0, 8'hFF, 16'hFFFF, 0, 1'b0, "R5 write ones");
        run_req(1'b0, 8'h00, 16'h0000, 1, 1'b0, "R5 write zeros");
        run_req(1'b0, 8'h01, 16'h8001, 2, 1'b1, "R7 R8 disturbed write");
        run_req(1'b1, 8'h80, 16'h1234, 1, 1'b1, "R7 R8 disturbed index");

        // R10: reset mid-frame drops the transfer
        @(negedge clk);
        req_valid = 1'b1; req_index_only = 1'b0; req_reg = 8'h3C; req_data = 16'h0F0F;
        unit_div = DIV_W'(1);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (60) @(negedge clk);
        check("R10 mid-frame cs low before reset", {7'd0, lcd_cs_n}, 8'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 lines idle after reset", {5'd0, lcd_cs_n, lcd_sclk, lcd_sdo}, 8'h07);
        check("R10 busy/done cleared", {6'd0, busy, done}, 8'h00);
        repeat (20) @(negedge clk);
        check("R10 R1 stays idle", {4'd0, lcd_cs_n, lcd_sclk, lcd_sdo, busy}, 8'h0E);
        run_req(1'b0, 8'hC3, 16'h3C96, 0, 1'b0, "R10 write after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule